// File: doc/BRIEF.md
# Packet Buffer Memory Manager

This block manages a packet buffer that is split into fixed-size pages. A host issues commands through a write-only command register. The commands allocate a numbered packet made of one or more pages, free packets page by page, and move packet numbers through three queues: transmit, transmit-completion and receive. The MAC side sees these queues as plain push and pop ports. The block does not hold the packet data.

An allocation finishes in one cycle and leaves its outcome in a result register. A release takes one cycle for each page it frees, and a busy flag stays high for the whole release. Any command written while busy is high is dropped. The host reads the busy flag, the result register, the packet-number register, the receive-queue head and empty status, and two interrupt flags.

Top module: `pkt_buf_mgr`

## Requirements
- R1: A command write (`cmd_we_i`) is accepted only when `busy_o` is low. A write made while `busy_o` is high has no effect on any state.
- R2: Command 1 (allocate) requests `size_i`+1 pages. It takes the lowest unused packet number and the lowest free pages. On the next cycle `ares_o` shows {bit5=0, bits4:0=packet number}. When too few pages are free, or no packet number is unused, `ares_o` becomes 6'h20 (bit5=1 means failed). `busy_o` stays low.
- R3: A successful allocation sets `alloc_int_o` when `alloc_ie_i` is high. The flag stays set until `alloc_ack_i` is pulsed or command 2 runs. A failed allocation never sets it.
- R4: Command 2 frees all pages and all packet numbers, empties all three queues and clears `alloc_int_o`, all in one cycle.
- R5: Command 3 pops the receive-queue head and shows the next entry, if there is one. It frees no memory. It has no effect when the receive queue is empty.
- R6: Command 4 pops the receive-queue head and frees all pages of that packet. `busy_o` stays high for P+1 cycles, where P is that packet's page count. It has no effect when the receive queue is empty.
- R7: Command 5 frees all pages of the packet named in `pnr_o`. `busy_o` stays high for P+1 cycles, so a packet with no pages gives one busy cycle.
- R8: Command 6 pushes `pnr_o` into the transmit queue. The MAC reads `tx_head_o` and pops with `tx_pop_i`.
- R9: Command 7 empties the transmit queue and the transmit-completion queue in one cycle. It frees no pages and leaves the receive queue unchanged.
- R10: All three queues are first-in first-out and hold QDEPTH entries (default 8). A push into a full queue is dropped, and a pop from an empty queue is ignored.
- R11: `rx_int_o` is high exactly when the receive queue holds at least one entry.
- R12: A pulse on `pnr_we_i` loads `pnr_i` into the packet-number register, which reads back on `pnr_o` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_i | input | 3 | Command code |
| size_i | input | 3 | Allocation size field N, pages = N+1 |
| pnr_we_i | input | 1 | Packet-number register write strobe |
| pnr_i | input | 5 | Packet-number write data |
| pnr_o | output | 5 | Packet-number register |
| alloc_ie_i | input | 1 | Allocation interrupt enable |
| alloc_ack_i | input | 1 | Clears the allocation interrupt |
| ares_o | output | 6 | Allocation result {failed, packet} |
| alloc_int_o | output | 1 | Allocation interrupt flag |
| busy_o | output | 1 | Command in progress |
| tx_head_o | output | 5 | Transmit queue head |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_pop_i | input | 1 | MAC pops transmit queue |
| txc_push_i | input | 1 | MAC pushes completion entry |
| txc_pkt_i | input | 5 | Completion packet number |
| txc_head_o | output | 5 | Completion queue head |
| txc_empty_o | output | 1 | Completion queue empty |
| txc_pop_i | input | 1 | Host pops completion queue |
| rx_push_i | input | 1 | MAC pushes received packet |
| rx_pkt_i | input | 5 | Received packet number |
| rx_head_o | output | 5 | Receive queue head |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_int_o | output | 1 | Receive interrupt, queue not empty |

## Verification
The bench fills the buffer exactly, so a wrong page count or a wrong choice of free pages turns up as a success or failure where the other was expected. It then frees a packet and allocates again, which shows whether the lowest packet number is reused and whether the pages really came back. The busy length is counted for an eight-page packet and for a packet that owns no pages. An off-by-one in the release sequencer changes those counts, and a design that starts commands while busy lets a transmit enqueue or an allocation slip through. Memory is checked again after a transmit-queue reset and after a plain receive pop, since a design that freed pages on either would let a later allocation succeed. The queues are also pushed one entry past full and drained, so that a wrapping pointer or a lost entry shows up as a wrong order.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  localparam int unsigned CMD_W  = 3;
  localparam int unsigned SIZE_W = 3;
  localparam int unsigned PKT_W  = 5;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP      = 3'd0,
    CMD_ALLOC    = 3'd1,
    CMD_RESET    = 3'd2,
    CMD_RX_POP   = 3'd3,
    CMD_RX_FREE  = 3'd4,
    CMD_REL_PKT  = 3'd5,
    CMD_TX_ENQ   = 3'd6,
    CMD_TX_RESET = 3'd7
  } cmd_e;
endpackage

// File: rtl/pbm_fifo.sv
module pbm_fifo #(
  parameter int unsigned W     = 5,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_pop, do_push;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign head_o  = mem_q[rd_q];
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/pbm_page_table.sv
module pbm_page_table #(
  parameter int unsigned NPAGES = 32,
  parameter int unsigned PKT_W  = 5,
  parameter int unsigned NEED_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             alloc_i,
  input  logic [NEED_W-1:0] need_i,
  output logic             alloc_ok_o,
  output logic [PKT_W-1:0] alloc_pkt_o,
  input  logic [PKT_W-1:0] rel_pkt_i,
  input  logic             rel_step_i,
  input  logic             rel_done_i,
  output logic             rel_hit_o
);
  localparam int unsigned NPKT = 2 ** PKT_W;
  localparam int unsigned CW   = $clog2(NPAGES + 1);
  localparam int unsigned PW   = (NPAGES > 1) ? $clog2(NPAGES) : 1;

  logic [NPAGES-1:0] pg_used_q;
  logic [PKT_W-1:0]  pg_own_q [NPAGES];
  logic [NPKT-1:0]   pkt_used_q;

  logic [NPAGES-1:0] take;
  logic [CW-1:0]     free_cnt;
  logic              pkt_found;
  logic [PKT_W-1:0]  pkt_idx;
  logic [PW-1:0]     rel_idx;

  // lowest free pages up to the requested count
  always_comb begin
    logic [CW-1:0] acc;
    acc = '0;
    for (int i = 0; i < NPAGES; i++) begin
      take[i] = !pg_used_q[i] && (acc < CW'(need_i));
      if (!pg_used_q[i]) acc = acc + 1'b1;
    end
    free_cnt = acc;
  end

  always_comb begin
    pkt_found = 1'b0;
    pkt_idx   = '0;
    for (int i = NPKT - 1; i >= 0; i--) begin
      if (!pkt_used_q[i]) begin
        pkt_found = 1'b1;
        pkt_idx   = PKT_W'(i);
      end
    end
  end

  always_comb begin
    rel_hit_o = 1'b0;
    rel_idx   = '0;
    for (int i = NPAGES - 1; i >= 0; i--) begin
      if (pg_used_q[i] && pg_own_q[i] == rel_pkt_i) begin
        rel_hit_o = 1'b1;
        rel_idx   = PW'(i);
      end
    end
  end

  assign alloc_ok_o  = pkt_found && (free_cnt >= CW'(need_i));
  assign alloc_pkt_o = pkt_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_used_q  <= '0;
      pkt_used_q <= '0;
    end else if (clr_i) begin
      pg_used_q  <= '0;
      pkt_used_q <= '0;
    end else if (alloc_i && alloc_ok_o) begin
      pg_used_q           <= pg_used_q | take;
      pkt_used_q[pkt_idx] <= 1'b1;
    end else if (rel_step_i && rel_hit_o) begin
      pg_used_q[rel_idx] <= 1'b0;
    end else if (rel_done_i) begin
      pkt_used_q[rel_pkt_i] <= 1'b0;
    end
  end

  generate
    for (genvar g = 0; g < NPAGES; g++) begin : g_own
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                             pg_own_q[g] <= '0;
        else if (alloc_i && alloc_ok_o && take[g]) pg_own_q[g] <= pkt_idx;
      end
    end
  endgenerate
endmodule

// File: rtl/pkt_buf_mgr.sv
module pkt_buf_mgr
  import pbm_pkg::*;
#(
  parameter int unsigned NPAGES = 32,
  parameter int unsigned QDEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [2:0]       cmd_i,
  input  logic [2:0]       size_i,
  input  logic             pnr_we_i,
  input  logic [4:0]       pnr_i,
  output logic [4:0]       pnr_o,
  input  logic             alloc_ie_i,
  input  logic             alloc_ack_i,
  output logic [5:0]       ares_o,
  output logic             alloc_int_o,
  output logic             busy_o,
  output logic [4:0]       tx_head_o,
  output logic             tx_empty_o,
  input  logic             tx_pop_i,
  input  logic             txc_push_i,
  input  logic [4:0]       txc_pkt_i,
  output logic [4:0]       txc_head_o,
  output logic             txc_empty_o,
  input  logic             txc_pop_i,
  input  logic             rx_push_i,
  input  logic [4:0]       rx_pkt_i,
  output logic [4:0]       rx_head_o,
  output logic             rx_empty_o,
  output logic             rx_int_o
);
  localparam int unsigned NEED_W = SIZE_W + 1;

  logic             busy_q, int_q;
  logic [PKT_W-1:0] pnr_q, tgt_q;
  logic [PKT_W:0]   ares_q;
  cmd_e             cmd;
  logic             acc, do_alloc, do_reset, do_txrst, rx_pop, tx_push, start_rel;
  logic             alloc_ok, rel_hit, rel_step, rel_done;
  logic [PKT_W-1:0] alloc_pkt;
  logic             tx_full, txc_full, rx_full;

  assign cmd       = cmd_e'(cmd_i);
  assign acc       = cmd_we_i && !busy_q;
  assign do_alloc  = acc && cmd == CMD_ALLOC;
  assign do_reset  = acc && cmd == CMD_RESET;
  assign do_txrst  = acc && cmd == CMD_TX_RESET;
  assign tx_push   = acc && cmd == CMD_TX_ENQ;
  assign rx_pop    = acc && (cmd == CMD_RX_POP || cmd == CMD_RX_FREE) && !rx_empty_o;
  assign start_rel = (acc && cmd == CMD_REL_PKT) ||
                     (acc && cmd == CMD_RX_FREE && !rx_empty_o);
  assign rel_step  = busy_q && rel_hit;
  assign rel_done  = busy_q && !rel_hit;

  pbm_page_table #(.NPAGES(NPAGES), .PKT_W(PKT_W), .NEED_W(NEED_W)) u_pt (
    .clk_i, .rst_ni,
    .clr_i      (do_reset),
    .alloc_i    (do_alloc),
    .need_i     (NEED_W'(size_i) + 1'b1),
    .alloc_ok_o (alloc_ok),
    .alloc_pkt_o(alloc_pkt),
    .rel_pkt_i  (tgt_q),
    .rel_step_i (rel_step),
    .rel_done_i (rel_done),
    .rel_hit_o  (rel_hit)
  );

  pbm_fifo #(.W(PKT_W), .DEPTH(QDEPTH)) u_txq (
    .clk_i, .rst_ni,
    .clr_i(do_reset || do_txrst), .push_i(tx_push), .data_i(pnr_q),
    .pop_i(tx_pop_i), .head_o(tx_head_o), .empty_o(tx_empty_o), .full_o(tx_full)
  );

  pbm_fifo #(.W(PKT_W), .DEPTH(QDEPTH)) u_txcq (
    .clk_i, .rst_ni,
    .clr_i(do_reset || do_txrst), .push_i(txc_push_i), .data_i(txc_pkt_i),
    .pop_i(txc_pop_i), .head_o(txc_head_o), .empty_o(txc_empty_o), .full_o(txc_full)
  );

  pbm_fifo #(.W(PKT_W), .DEPTH(QDEPTH)) u_rxq (
    .clk_i, .rst_ni,
    .clr_i(do_reset), .push_i(rx_push_i), .data_i(rx_pkt_i),
    .pop_i(rx_pop), .head_o(rx_head_o), .empty_o(rx_empty_o), .full_o(rx_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tgt_q  <= '0;
      pnr_q  <= '0;
      ares_q <= '0;
      int_q  <= 1'b0;
    end else begin
      if (pnr_we_i) pnr_q <= pnr_i;
      if (start_rel) begin
        busy_q <= 1'b1;
        tgt_q  <= (cmd == CMD_RX_FREE) ? rx_head_o : pnr_q;
      end else if (rel_done) begin
        busy_q <= 1'b0;
      end
      if (do_alloc) ares_q <= alloc_ok ? {1'b0, alloc_pkt} : {1'b1, {PKT_W{1'b0}}};
      if (do_reset)                          int_q <= 1'b0;
      else if (do_alloc && alloc_ok && alloc_ie_i) int_q <= 1'b1;
      else if (alloc_ack_i)                  int_q <= 1'b0;
    end
  end

  assign busy_o      = busy_q;
  assign pnr_o       = pnr_q;
  assign ares_o      = ares_q;
  assign alloc_int_o = int_q;
  assign rx_int_o    = !rx_empty_o;
endmodule

// File: rtl/pkt_buf_mgr_chk.sv
module pkt_buf_mgr_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_we_i,
  input logic [2:0] cmd_i,
  input logic       alloc_ie_i,
  input logic       rx_push_i,
  input logic [5:0] ares_o,
  input logic       alloc_int_o,
  input logic       busy_o,
  input logic       tx_empty_o,
  input logic       txc_empty_o,
  input logic       rx_empty_o
);
  logic acc;
  assign acc = cmd_we_i && !busy_o;

  assert_busy_blocks_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(ares_o));

  assert_alloc_no_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_i == 3'd1) |=> !busy_o);

  assert_int_needs_enable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alloc_int_o) |-> $past(alloc_ie_i));

  assert_reset_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_i == 3'd2) |=> (rx_empty_o && tx_empty_o && txc_empty_o && !alloc_int_o));

  assert_rx_pop_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_i == 3'd3 && rx_empty_o && !rx_push_i) |=> rx_empty_o);

  assert_release_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_i == 3'd5) |=> busy_o);

  assert_txreset_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_i == 3'd7) |=> (tx_empty_o && txc_empty_o));
endmodule

bind pkt_buf_mgr pkt_buf_mgr_chk u_chk (.*);

// File: tb/pkt_buf_mgr_test.sv
module pkt_buf_mgr_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_we_i = 1'b0;
  logic [2:0] cmd_i = '0;
  logic [2:0] size_i = '0;
  logic       pnr_we_i = 1'b0;
  logic [4:0] pnr_i = '0;
  logic [4:0] pnr_o;
  logic       alloc_ie_i = 1'b0;
  logic       alloc_ack_i = 1'b0;
  logic [5:0] ares_o;
  logic       alloc_int_o, busy_o;
  logic [4:0] tx_head_o, txc_head_o, rx_head_o;
  logic       tx_empty_o, txc_empty_o, rx_empty_o, rx_int_o;
  logic       tx_pop_i = 1'b0;
  logic       txc_push_i = 1'b0;
  logic [4:0] txc_pkt_i = '0;
  logic       txc_pop_i = 1'b0;
  logic       rx_push_i = 1'b0;
  logic [4:0] rx_pkt_i = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  pkt_buf_mgr uut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic do_cmd(input logic [2:0] c, input logic [2:0] n);
    @(negedge clk_i);
    cmd_we_i = 1'b1; cmd_i = c; size_i = n;
    @(negedge clk_i);
    cmd_we_i = 1'b0; cmd_i = '0; size_i = '0;
  endtask

  task automatic set_pnr(input logic [4:0] p);
    @(negedge clk_i);
    pnr_we_i = 1'b1; pnr_i = p;
    @(negedge clk_i);
    pnr_we_i = 1'b0;
  endtask

  task automatic wait_idle(output int w);
    w = 0;
    while (busy_o) begin
      @(negedge clk_i);
      w++;
    end
  endtask

  task automatic alloc_exp(input logic [2:0] n, input int exp, input string req);
    do_cmd(3'd1, n);
    chk_eq(req, ares_o, exp);
    chk_eq({req, " busy"}, busy_o, 0);
  endtask

  task automatic release_exp(input logic [4:0] p, input int exp_w, input string req);
    int w;
    set_pnr(p);
    do_cmd(3'd5, 3'd0);
    wait_idle(w);
    chk_eq(req, w, exp_w);
  endtask

  task automatic rx_push(input logic [4:0] p);
    @(negedge clk_i);
    rx_push_i = 1'b1; rx_pkt_i = p;
    @(negedge clk_i);
    rx_push_i = 1'b0;
  endtask

  task automatic txc_push(input logic [4:0] p);
    @(negedge clk_i);
    txc_push_i = 1'b1; txc_pkt_i = p;
    @(negedge clk_i);
    txc_push_i = 1'b0;
  endtask

  task automatic tx_pop();
    @(negedge clk_i);
    tx_pop_i = 1'b1;
    @(negedge clk_i);
    tx_pop_i = 1'b0;
  endtask

  task automatic t_reset_state();
    chk_eq("R1 reset busy", busy_o, 0);
    chk_eq("R2 reset ares", ares_o, 0);
    chk_eq("R10 reset queues", {tx_empty_o, txc_empty_o, rx_empty_o}, 3'b111);
    chk_eq("R11 reset rx_int", rx_int_o, 0);
    chk_eq("R3 reset int", alloc_int_o, 0);
  endtask

  task automatic t_alloc_basic();
    alloc_ie_i = 1'b1;
    alloc_exp(3'd1, 6'h00, "R2 alloc 2 pages pkt0");
    chk_eq("R3 int set", alloc_int_o, 1);
    @(negedge clk_i); alloc_ack_i = 1'b1;
    @(negedge clk_i); alloc_ack_i = 1'b0;
    chk_eq("R3 int ack", alloc_int_o, 0);
    alloc_ie_i = 1'b0;
    alloc_exp(3'd0, 6'h01, "R2 alloc 1 page pkt1");
    chk_eq("R3 int disabled", alloc_int_o, 0);
  endtask

  task automatic t_fill();
    alloc_exp(3'd7, 6'h02, "R2 fill pkt2");
    alloc_exp(3'd7, 6'h03, "R2 fill pkt3");
    alloc_exp(3'd7, 6'h04, "R2 fill pkt4");
    alloc_ie_i = 1'b1;
    alloc_exp(3'd7, 6'h20, "R2 too few pages");
    chk_eq("R3 no int on fail", alloc_int_o, 0);
    alloc_ie_i = 1'b0;
    alloc_exp(3'd4, 6'h05, "R2 exact fit pkt5");
    alloc_exp(3'd0, 6'h20, "R2 full");
  endtask

  task automatic t_release();
    release_exp(5'd3, 9, "R7 release 8 pages busy");
    chk_eq("R12 pnr readback", pnr_o, 3);
    alloc_exp(3'd7, 6'h03, "R7 pages returned, pkt3 reused");
    release_exp(5'd20, 1, "R7 empty packet busy");
  endtask

  task automatic t_tx_queue();
    int w;
    set_pnr(5'd2); do_cmd(3'd6, 3'd0);
    chk_eq("R8 enq busy", busy_o, 0);
    set_pnr(5'd5); do_cmd(3'd6, 3'd0);
    chk_eq("R8 tx head", tx_head_o, 2);
    tx_pop();
    chk_eq("R8 tx second", tx_head_o, 5);
    tx_pop();
    chk_eq("R8 tx drained", tx_empty_o, 1);
    tx_pop();
    chk_eq("R10 pop empty", tx_empty_o, 1);
    txc_push(5'd7);
    chk_eq("R10 txc head", txc_head_o, 7);
    @(negedge clk_i); txc_pop_i = 1'b1;
    @(negedge clk_i); txc_pop_i = 1'b0;
    chk_eq("R10 txc drained", txc_empty_o, 1);
    // enqueue during release must be dropped
    set_pnr(5'd1);
    do_cmd(3'd5, 3'd0);
    do_cmd(3'd6, 3'd0);
    chk_eq("R1 enq while busy dropped", tx_empty_o, 1);
    wait_idle(w);
  endtask

  task automatic t_tx_reset();
    set_pnr(5'd2); do_cmd(3'd6, 3'd0);
    txc_push(5'd3);
    rx_push(5'd9);
    do_cmd(3'd7, 3'd0);
    chk_eq("R9 tx emptied", tx_empty_o, 1);
    chk_eq("R9 txc emptied", txc_empty_o, 1);
    chk_eq("R9 rx kept", rx_head_o, 9);
    alloc_exp(3'd1, 6'h20, "R9 memory kept");
    alloc_exp(3'd0, 6'h01, "R9 single free page");
    do_cmd(3'd3, 3'd0);
    chk_eq("R5 rx cleared", rx_empty_o, 1);
  endtask

  task automatic t_rx();
    int w;
    rx_push(5'd4);
    rx_push(5'd2);
    chk_eq("R11 rx_int", rx_int_o, 1);
    chk_eq("R5 rx head", rx_head_o, 4);
    do_cmd(3'd3, 3'd0);
    chk_eq("R5 next head", rx_head_o, 2);
    chk_eq("R5 no busy", busy_o, 0);
    alloc_exp(3'd0, 6'h20, "R5 no memory freed");
    do_cmd(3'd4, 3'd0);
    wait_idle(w);
    chk_eq("R6 busy cycles", w, 9);
    chk_eq("R6 rx popped", rx_empty_o, 1);
    chk_eq("R11 rx_int low", rx_int_o, 0);
    alloc_exp(3'd7, 6'h02, "R6 pages freed");
    do_cmd(3'd4, 3'd0);
    chk_eq("R6 empty no busy", busy_o, 0);
    do_cmd(3'd3, 3'd0);
    chk_eq("R5 pop empty", rx_empty_o, 1);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 9; i++) rx_push(5'(10 + i));
    for (int i = 0; i < 8; i++) begin
      chk_eq("R10 rx order", rx_head_o, 10 + i);
      do_cmd(3'd3, 3'd0);
    end
    chk_eq("R10 overflow dropped", rx_empty_o, 1);
  endtask

  task automatic t_busy_ignore();
    int w;
    set_pnr(5'd4);
    do_cmd(3'd5, 3'd0);
    do_cmd(3'd1, 3'd0);
    chk_eq("R1 alloc while busy dropped", ares_o, 6'h02);
    wait_idle(w);
    alloc_ie_i = 1'b1;
    alloc_exp(3'd7, 6'h04, "R1 pkt4 reused after release");
    alloc_ie_i = 1'b0;
  endtask

  task automatic t_mgr_reset();
    rx_push(5'd1);
    set_pnr(5'd0); do_cmd(3'd6, 3'd0);
    chk_eq("R3 int before reset", alloc_int_o, 1);
    do_cmd(3'd2, 3'd0);
    chk_eq("R4 queues empty", {tx_empty_o, txc_empty_o, rx_empty_o}, 3'b111);
    chk_eq("R4 int cleared", alloc_int_o, 0);
    alloc_exp(3'd7, 6'h00, "R4 all free pkt0");
    alloc_exp(3'd7, 6'h01, "R4 all free pkt1");
    alloc_exp(3'd7, 6'h02, "R4 all free pkt2");
    alloc_exp(3'd7, 6'h03, "R4 all free pkt3");
    alloc_exp(3'd0, 6'h20, "R4 full again");
  endtask

  initial begin
    #100000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset_state();
    t_alloc_basic();
    t_fill();
    t_release();
    t_tx_queue();
    t_tx_reset();
    t_rx();
    t_overflow();
    t_busy_ignore();
    t_mgr_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule